// File: doc/BRIEF.md
# Virtually Indexed Physically Tagged Data Cache

This block is the lookup stage of a 16 KB, 4-way set-associative data cache in a 32-bit physical address space. Lines are 32 bytes, and there are 128 sets. The set index and the word select lie entirely inside the 12-bit page offset, and those bits are the same before and after translation. A request therefore carries only the page-offset bits of the virtual address. The block latches the set at once, while the address translation runs elsewhere. The tag comparison starts only when the physical page number arrives on its own strobe, normally one cycle later and possibly more.

On a hit the addressed 32-bit word is returned, or updated on a store. On a miss the block raises a line-fill request carrying the 27-bit line address. It writes the eight returned words into a victim way and then replays the original access against the new line. The victim is the lowest-numbered invalid way if the set has one; otherwise a per-set pseudo-LRU tree chooses it. The block accepts one request at a time.

Top module: `vipt_dcache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, and `fill_req` and `rsp_valid` are 0. The first access to any set after reset misses.
- R2: The set is taken from `req_pgoff[11:5]` in the cycle the request is accepted. The tag compared is the `ppn` value presented with `ppn_valid`.
- R3: The block waits in lookup for any number of cycles until `ppn_valid` is high. A hit response (`rsp_valid`=1, `rsp_hit`=1) appears in the cycle after the `ppn_valid` cycle. No response or fill request appears before it.
- R4: A read hit returns the 32-bit word selected by `req_pgoff[4:2]` (word 0 is at the lowest address in the line).
- R5: On a miss, `fill_req` rises in the cycle after `ppn_valid`. `fill_addr` = {ppn, set} is held stable, and `fill_req` stays high through gaps, until eight `fill_valid` beats arrive in word order 0 to 7.
- R6: The cycle after the eighth beat, `fill_req` is low. In the following cycle the replayed access responds with `rsp_valid`=1, `rsp_hit`=0 and the data taken from the new line.
- R7: A store writes `req_wdata` into the addressed word on a hit, or into the newly filled line on a miss, and `rsp_rdata` returns the stored word. Later reads see that word while the line is resident.
- R8: On a miss, if the set has an invalid way, the lowest-numbered invalid way is filled.
- R9: If all four ways are valid, the victim comes from a 3-bit tree. Bit0 = 0 selects ways 0/1 and bit0 = 1 selects ways 2/3. Within the chosen pair, bit1 (left pair) or bit2 (right pair) gives the low way bit. An access to way w sets bit0 to the opposite half and the pair bit to the other way of its pair. Tree bits are 0 after reset.
- R10: `req_ready` is 0 from acceptance until the response cycle. `req_valid` is ignored while `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_pgoff | input | 12 | Page-offset bits of the virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 32 | Store data |
| ppn_valid | input | 1 | Physical page number is valid this cycle |
| ppn | input | 20 | Physical page number from translation |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_hit | output | 1 | 1 if the original lookup hit |
| rsp_rdata | output | 32 | Loaded or stored word |
| fill_req | output | 1 | Line fill requested |
| fill_addr | output | 27 | Line address {ppn, set} |
| fill_valid | input | 1 | Fill beat valid |
| fill_data | input | 32 | Fill beat word |

## Verification
The hardest situation to reach is the tree-chosen eviction. It needs a set with all four ways valid and a history of hits that has moved the tree bits. Only the hit/miss pattern of later accesses shows which way left. The bench drives long runs of accesses to a few sets from a pool of six physical pages. A page-order pattern keeps every set full and makes evictions frequent. A bench model of the tree predicts each hit, miss and fill address. Stores, stalled fill beats, late page numbers and requests raised while the block is busy are mixed into the same runs.

// File: rtl/vipt_dcache.sv
module vipt_dcache #(
  parameter int IDX_W = 7,
  parameter int OFF_W = 5,
  parameter int TAG_W = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [IDX_W+OFF_W-1:0] req_pgoff,
  input  logic                   req_write,
  input  logic [31:0]            req_wdata,
  input  logic                   ppn_valid,
  input  logic [TAG_W-1:0]       ppn,
  output logic                   rsp_valid,
  output logic                   rsp_hit,
  output logic [31:0]            rsp_rdata,
  output logic                   fill_req,
  output logic [TAG_W+IDX_W-1:0] fill_addr,
  input  logic                   fill_valid,
  input  logic [31:0]            fill_data
);
  localparam int SETS  = 1 << IDX_W;
  localparam int WAYS  = 4;
  localparam int WW    = OFF_W - 2;
  localparam int WORDS = 1 << WW;

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_FILL, S_REPLAY} st_t;

  st_t st_q;
  logic [TAG_W-1:0] tag_q [SETS*WAYS];
  logic [31:0]      dat_q [SETS*WAYS*WORDS];
  logic [SETS*WAYS-1:0] vld_q;
  logic [2:0]       lru_q [SETS];

  logic [IDX_W-1:0] idx_q;
  logic [WW-1:0]    wsel_q, beat_q;
  logic             wr_q;
  logic [31:0]      wdata_q;
  logic [TAG_W-1:0] ptag_q;
  logic [1:0]       vway_q;

  logic [WAYS-1:0]  way_hit, way_inv;
  logic [1:0]       hit_way, victim, acc_way;
  logic             acc_go, fill_we, last_beat;
  logic [2:0]       cur_lru, nxt_lru;
  logic             unused_byte;

  assign unused_byte = ^req_pgoff[1:0];
  assign req_ready = (st_q == S_IDLE);
  assign fill_req  = (st_q == S_FILL);
  assign fill_addr = {ptag_q, idx_q};

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    assign way_hit[g] = vld_q[{idx_q, 2'(g)}] && (tag_q[{idx_q, 2'(g)}] == ppn);
    assign way_inv[g] = !vld_q[{idx_q, 2'(g)}];
  end

  always_comb begin
    hit_way = 2'd0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (way_hit[i]) hit_way = 2'(i);
  end

  assign cur_lru = lru_q[idx_q];

  always_comb begin
    if      (way_inv[0]) victim = 2'd0;
    else if (way_inv[1]) victim = 2'd1;
    else if (way_inv[2]) victim = 2'd2;
    else if (way_inv[3]) victim = 2'd3;
    else if (!cur_lru[0]) victim = {1'b0, cur_lru[1]};
    else                  victim = {1'b1, cur_lru[2]};
  end

  assign acc_go  = (st_q == S_REPLAY) || (st_q == S_LOOK && ppn_valid && |way_hit);
  assign acc_way = (st_q == S_REPLAY) ? vway_q : hit_way;

  always_comb begin
    nxt_lru = cur_lru;
    if (!acc_way[1]) begin
      nxt_lru[0] = 1'b1;
      nxt_lru[1] = ~acc_way[0];
    end else begin
      nxt_lru[0] = 1'b0;
      nxt_lru[2] = ~acc_way[0];
    end
  end

  assign fill_we   = (st_q == S_FILL) && fill_valid;
  assign last_beat = (beat_q == WW'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (fill_we)
      dat_q[{idx_q, vway_q, beat_q}] <= fill_data;
    else if (acc_go && wr_q)
      dat_q[{idx_q, acc_way, wsel_q}] <= wdata_q;
    if (fill_we && last_beat)
      tag_q[{idx_q, vway_q}] <= ptag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      vld_q     <= '0;
      for (int s = 0; s < SETS; s++) lru_q[s] <= 3'b000;
      idx_q     <= '0;
      wsel_q    <= '0;
      beat_q    <= '0;
      wr_q      <= 1'b0;
      wdata_q   <= '0;
      ptag_q    <= '0;
      vway_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (acc_go) begin
        lru_q[idx_q] <= nxt_lru;
        rsp_valid    <= 1'b1;
        rsp_hit      <= (st_q == S_LOOK);
        rsp_rdata    <= wr_q ? wdata_q : dat_q[{idx_q, acc_way, wsel_q}];
      end
      case (st_q)
        S_IDLE: if (req_valid) begin
          idx_q   <= req_pgoff[IDX_W+OFF_W-1:OFF_W];
          wsel_q  <= req_pgoff[OFF_W-1:2];
          wr_q    <= req_write;
          wdata_q <= req_wdata;
          st_q    <= S_LOOK;
        end
        S_LOOK: if (ppn_valid) begin
          ptag_q <= ppn;
          if (|way_hit) st_q <= S_IDLE;
          else begin
            vway_q <= victim;
            beat_q <= '0;
            st_q   <= S_FILL;
          end
        end
        S_FILL: if (fill_valid) begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) begin
            vld_q[{idx_q, vway_q}] <= 1'b1;
            st_q <= S_REPLAY;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vipt_dcache_chk.sv
module vipt_dcache_chk #(
  parameter int FA_W = 27
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            ppn_valid,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            fill_req,
  input logic [FA_W-1:0] fill_addr
);
  p_ready_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> !req_ready);

  p_fill_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && $past(fill_req) |-> $stable(fill_addr));

  p_rsp_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_hit_after_ppn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> $past(ppn_valid));

  p_replay_after_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fill_req) |=> rsp_valid && !rsp_hit);

  p_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);
endmodule

bind vipt_dcache vipt_dcache_chk #(.FA_W(TAG_W + IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .ppn_valid(ppn_valid),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .fill_req(fill_req), .fill_addr(fill_addr)
);

// File: tb/sim_vipt_dcache.sv
`timescale 1ns/1ps
module sim_vipt_dcache;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, ppn_valid = 0, fill_valid = 0;
  logic [11:0] req_pgoff = 0;
  logic [31:0] req_wdata = 0, fill_data = 0;
  logic [19:0] ppn = 0;
  logic req_ready, rsp_valid, rsp_hit, fill_req;
  logic [31:0] rsp_rdata;
  logic [26:0] fill_addr;

  int checks = 0, fails = 0;
  bit m_vld [128][4];
  logic [19:0] m_tag [128][4];
  logic [2:0]  m_lru [128];
  logic [31:0] m_dat [128][4][8];

  always #2 clk = ~clk;

  vipt_dcache u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_pgoff(req_pgoff), .req_write(req_write), .req_wdata(req_wdata),
    .ppn_valid(ppn_valid), .ppn(ppn), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_rdata(rsp_rdata), .fill_req(fill_req), .fill_addr(fill_addr),
    .fill_valid(fill_valid), .fill_data(fill_data));

  function automatic logic [31:0] mem_word(input logic [26:0] line, input int w);
    return (32'(line) * 32'h9E3779B1) ^ (32'(w) * 32'h01010101) ^ 32'h5A5A0000;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_access(input int s, input logic [19:0] tg, input int w, input bit wr,
                           input logic [31:0] wd, input int dly, input bit junk, input string rq);
    bit hit, inv, gap;
    int way;
    logic [31:0] ed;
    hit = 0; way = 0; inv = 0; gap = ((s + w) % 2) == 1;
    for (int i = 0; i < 4; i++)
      if (!hit && m_vld[s][i] && m_tag[s][i] == tg) begin hit = 1; way = i; end
    if (!hit) begin
      for (int i = 3; i >= 0; i--) if (!m_vld[s][i]) begin inv = 1; way = i; end
      if (!inv) way = m_lru[s][0] ? (m_lru[s][2] ? 3 : 2) : (m_lru[s][1] ? 1 : 0);
      m_vld[s][way] = 1; m_tag[s][way] = tg;
      for (int b = 0; b < 8; b++) m_dat[s][way][b] = mem_word({tg, 7'(s)}, b);
    end
    if (way < 2) begin m_lru[s][0] = 1; m_lru[s][1] = (way % 2 == 0); end
    else         begin m_lru[s][0] = 0; m_lru[s][2] = (way % 2 == 0); end
    if (wr) m_dat[s][way][w] = wd;
    ed = m_dat[s][way][w];

    @(negedge clk);
    chk(req_ready == 1, "R10 ready before request", 64'(req_ready), 1);
    req_valid = 1; req_pgoff = {7'(s), 3'(w), 2'(s & 3)}; req_write = wr; req_wdata = wd;
    @(negedge clk);
    chk(req_ready == 0, "R10 busy after accept", 64'(req_ready), 0);
    if (junk) begin req_pgoff = ~req_pgoff; req_write = ~wr; req_wdata = ~wd; end
    else req_valid = 0;
    if (dly == 0) begin ppn_valid = 1; ppn = tg; end
    for (int i = 1; i <= dly; i++) begin
      @(negedge clk);
      req_valid = 0;
      chk(!rsp_valid && !fill_req, "R3 waits for ppn", {rsp_valid, fill_req}, 0);
      if (i == dly) begin ppn_valid = 1; ppn = tg; end
    end
    @(negedge clk);
    ppn_valid = 0; req_valid = 0; ppn = ~tg;
    if (hit) begin
      chk(rsp_valid && rsp_hit && !fill_req, rq, {rsp_valid, rsp_hit, fill_req}, 3'b110);
      chk(rsp_rdata == ed, wr ? "R7 store hit data" : "R4 load hit word", rsp_rdata, ed);
    end else begin
      chk(fill_req && !rsp_valid, inv ? "R8 miss with free way" : rq, {fill_req, rsp_valid}, 2'b10);
      chk(fill_addr == {tg, 7'(s)}, "R5 fill address", fill_addr, {tg, 7'(s)});
      for (int b = 0; b < 8; b++) begin
        fill_valid = 1; fill_data = mem_word({tg, 7'(s)}, b);
        @(negedge clk);
        fill_valid = 0;
        if (gap && b < 7) begin
          chk(fill_req && fill_addr == {tg, 7'(s)}, "R5 fill held in gap", {fill_req, fill_addr}, {1'b1, tg, 7'(s)});
          @(negedge clk);
        end
      end
      chk(!fill_req && !rsp_valid, "R6 replay cycle", {fill_req, rsp_valid}, 0);
      @(negedge clk);
      chk(rsp_valid && !rsp_hit, "R6 replay response", {rsp_valid, rsp_hit}, 2'b10);
      chk(rsp_rdata == ed, wr ? "R7 store miss data" : "R6 replay data", rsp_rdata, ed);
    end
  endtask

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < 128; s++) begin
      m_lru[s] = 0;
      for (int i = 0; i < 4; i++) begin m_vld[s][i] = 0; m_tag[s][i] = 0; end
    end
    repeat (3) @(negedge clk);
    chk(req_ready && !fill_req && !rsp_valid, "R1 reset outputs", {req_ready, fill_req, rsp_valid}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !fill_req && !rsp_valid, "R1 after release", {req_ready, fill_req, rsp_valid}, 3'b100);
    // R1 R2: every set misses first, set from page-offset bits
    for (int s = 0; s < 128; s++)
      do_access(s, 20'h01000 + 20'(s), s % 8, 0, 0, s % 3, (s % 5) == 0, "R1 first access misses");
    // R4: second pass hits every word position
    for (int s = 0; s < 128; s++)
      do_access(s, 20'h01000 + 20'(s), (s * 3) % 8, 0, 0, (s + 1) % 3, (s % 4) == 1, "R2 hit on stored tag");
    // R7 R9: conflict runs on few sets with a page pool of six
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < 90; k++)
        do_access((p == 0) ? 3 : (p == 1) ? 64 : 127,
                  20'hA0000 + 20'((k * k + k / 3 + p) % 6), (k * 5) % 8,
                  (k % 3) == 0, 32'hC0DE0000 + 32'(k * 17 + p), k % 4, (k % 7) == 0,
                  "R9 tree victim hit/miss");
    // R9: explicit fill order then eviction in set 9
    for (int t = 0; t < 4; t++) do_access(9, 20'hB0000 + 20'(t), t, 0, 0, 1, 0, "R8 fill order");
    do_access(9, 20'hB0000, 2, 0, 0, 0, 0, "R9 hit way0");
    do_access(9, 20'hB0004, 1, 0, 0, 0, 0, "R9 evict");
    do_access(9, 20'hB0002, 5, 0, 0, 0, 0, "R9 way2 evicted");
    do_access(9, 20'hB0000, 7, 1, 32'h12345678, 2, 0, "R9 way0 kept");
    do_access(9, 20'hB0000, 7, 0, 0, 0, 0, "R7 store persists");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule